// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Unit

This unit executes the reserve-then-conditionally-store atomic pair for a 32-bit or 64-bit integer core. A pipeline hands it one request at a time through a valid/ready handshake. Each request carries the operation, the access width, the base-register address (used unmodified, with no displacement), the acquire/release ordering bits, the store operand and the destination register index. The unit checks the request, drives a single-beat memory port when an access is needed, and returns a result. The result holds the destination value, a retire flag and an exception cause.

The unit keeps one reservation. It is a valid flag plus an address tag at doubleword granularity. A load-reserved that completes sets the reservation. Any store-conditional clears it, whether it succeeds, fails or traps. Any exception and reset also clear it. A store-conditional compares its address against the reservation before any memory write is issued. If there is no match, it fails at once and no memory traffic occurs. The ordering bits are not interpreted. They are only passed along with the memory request.

Top module: `lrsc_unit`

## Requirements
- R1: `req_ready_o` is high exactly when no operation is in progress. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. Only one operation is in progress at a time.
- R2: Width encoding is 0 byte, 1 halfword, 2 word, 3 doubleword. Word is always legal. Doubleword is legal only when XLEN is 64. Byte and halfword are illegal: the request returns cause 2 without retiring, and no memory access is made.
- R3: Alignment rules: a halfword needs address bit 0 clear, a word needs bits 1:0 clear, a doubleword needs bits 2:0 clear. A misaligned request makes no memory access. A misaligned load-reserved (op 0) returns cause 4. A misaligned store-conditional (op 1) returns cause 6, even if its address matches the reservation.
- R4: A legal, aligned load-reserved issues a memory read at the request address with the request width. On a good response it retires. It returns the low 32 bits of read data sign-extended for a word, or the full value for a doubleword.
- R5: A completed load-reserved sets the reservation to its address with bits 2:0 ignored.
- R6: A store-conditional with no valid reservation, or with a tag mismatch, retires with destination value 1 and makes no memory access.
- R7: A matching store-conditional issues one memory write. The write data is the low width bits of the store operand, zero-extended. The result is 0, or 1 when `mem_sc_fail_i` accompanies the response.
- R8: Every store-conditional, every exception and reset clear the reservation.
- R9: A memory error response returns cause 5 for a load-reserved or cause 7 for a store-conditional, without retiring. A retired result always has cause 0 and an exception always has a nonzero cause.
- R10: A memory request keeps its address, width, direction, data and the request's ordering bits unchanged until `mem_rsp_i` is sampled.
- R11: A result keeps `rsp_valid_o` and its fields unchanged until `rsp_ready_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit idle, request can be taken |
| req_op_i | input | 1 | 0 load-reserved, 1 store-conditional |
| req_size_i | input | 2 | Access width code |
| req_addr_i | input | XLEN | Base register value used as address |
| req_aq_i | input | 1 | Acquire bit |
| req_rl_i | input | 1 | Release bit |
| req_wdata_i | input | XLEN | Store operand |
| req_rd_i | input | 5 | Destination register index |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write when high |
| mem_size_o | output | 2 | Memory access width code |
| mem_addr_o | output | XLEN | Memory address |
| mem_wdata_o | output | XLEN | Memory write data, right-aligned |
| mem_aq_o | output | 1 | Forwarded acquire bit |
| mem_rl_o | output | 1 | Forwarded release bit |
| mem_rsp_i | input | 1 | Memory response for the current request |
| mem_rdata_i | input | XLEN | Memory read data, right-aligned |
| mem_err_i | input | 1 | Memory access error |
| mem_sc_fail_i | input | 1 | Conditional write not performed |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result accepted |
| rsp_rd_o | output | 5 | Destination register index |
| rsp_data_o | output | XLEN | Destination value |
| rsp_retire_o | output | 1 | Instruction retires |
| rsp_exc_o | output | 4 | Exception cause, 0 when retired |

## Verification
A corrupted reservation is not visible until the next store-conditional. That operation then shows it at the ports as a memory write that should not occur, or a missing one, and a destination value of the wrong polarity. This appears in the cycle after the request is taken. A wrong check order shows the same way: a misaligned conditional store that reaches memory or returns a result instead of cause 6. A wrong state in the sequencer shows in the next cycle as a dropped hold on the memory or result signals, or as a ready signal that rises while an operation is in progress. The bench therefore follows every reservation-changing event with a probing store-conditional. It also compares the handshake signals on every clock.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} lrsc_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_RSP} lrsc_state_e;
  localparam logic OP_LR = 1'b0;
  localparam logic OP_SC = 1'b1;
  localparam logic [3:0] EXC_NONE     = 4'd0;
  localparam logic [3:0] EXC_ILLEGAL  = 4'd2;
  localparam logic [3:0] EXC_LD_MISAL = 4'd4;
  localparam logic [3:0] EXC_LD_FAULT = 4'd5;
  localparam logic [3:0] EXC_ST_MISAL = 4'd6;
  localparam logic [3:0] EXC_ST_FAULT = 4'd7;
endpackage

// File: rtl/lrsc_access_chk.sv
module lrsc_access_chk
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0] size_i,
  input  logic [2:0] addr_lo_i,
  output logic       legal_o,
  output logic       aligned_o
);
  logic dbl_ok;
  generate
    if (XLEN == 64) begin : g_rv64
      assign dbl_ok = 1'b1;
    end else begin : g_rv32
      assign dbl_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (lrsc_size_e'(size_i))
      SZ_W:    begin legal_o = 1'b1;   aligned_o = (addr_lo_i[1:0] == 2'b00); end
      SZ_D:    begin legal_o = dbl_ok; aligned_o = (addr_lo_i == 3'b000);    end
      SZ_H:    begin legal_o = 1'b0;   aligned_o = ~addr_lo_i[0];            end
      default: begin legal_o = 1'b0;   aligned_o = 1'b1;                     end
    endcase
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int XLEN     = 64,
  parameter int GRAN_LSB = 3,
  localparam int TAG_W   = XLEN - GRAN_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic [TAG_W-1:0] cmp_tag_i,
  output logic             match_o
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end else if (set_i) begin
      vld_q <= 1'b1;
      tag_q <= set_tag_i;
    end
  end

  assign match_o = vld_q && (tag_q == cmp_tag_i);
endmodule

// File: rtl/lrsc_data_fmt.sv
module lrsc_data_fmt
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] ld_raw_i,
  input  logic [XLEN-1:0] st_raw_i,
  output logic [XLEN-1:0] ld_ext_o,
  output logic [XLEN-1:0] st_trim_o
);
  always_comb begin
    unique case (lrsc_size_e'(size_i))
      SZ_B: begin
        ld_ext_o  = {{(XLEN-8){ld_raw_i[7]}}, ld_raw_i[7:0]};
        st_trim_o = {{(XLEN-8){1'b0}}, st_raw_i[7:0]};
      end
      SZ_H: begin
        ld_ext_o  = {{(XLEN-16){ld_raw_i[15]}}, ld_raw_i[15:0]};
        st_trim_o = {{(XLEN-16){1'b0}}, st_raw_i[15:0]};
      end
      SZ_W: begin
        ld_ext_o  = {{(XLEN-32){ld_raw_i[31]}}, ld_raw_i[31:0]};
        st_trim_o = {{(XLEN-32){1'b0}}, st_raw_i[31:0]};
      end
      default: begin
        ld_ext_o  = ld_raw_i;
        st_trim_o = st_raw_i;
      end
    endcase
  end
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int RD_W = 5,
  localparam int GRAN_LSB = 3,
  localparam int TAG_W = XLEN - GRAN_LSB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_op_i,
  input  logic [1:0]      req_size_i,
  input  logic [XLEN-1:0] req_addr_i,
  input  logic            req_aq_i,
  input  logic            req_rl_i,
  input  logic [XLEN-1:0] req_wdata_i,
  input  logic [RD_W-1:0] req_rd_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [1:0]      mem_size_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_aq_o,
  output logic            mem_rl_o,
  input  logic            mem_rsp_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_err_i,
  input  logic            mem_sc_fail_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [RD_W-1:0] rsp_rd_o,
  output logic [XLEN-1:0] rsp_data_o,
  output logic            rsp_retire_o,
  output logic [3:0]      rsp_exc_o
);
  lrsc_state_e     state_q, state_d;
  logic            op_q, aq_q, rl_q;
  logic [1:0]      size_q;
  logic [XLEN-1:0] addr_q, wdata_q, data_q, data_d;
  logic [RD_W-1:0] rd_q;
  logic            retire_q, retire_d;
  logic [3:0]      exc_q, exc_d;
  logic            accept, legal, aligned, resv_hit, resv_set, resv_clr;
  logic [XLEN-1:0] ld_ext, st_trim;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  lrsc_access_chk #(.XLEN(XLEN)) u_chk (
    .size_i   (req_size_i),
    .addr_lo_i(req_addr_i[2:0]),
    .legal_o  (legal),
    .aligned_o(aligned)
  );

  lrsc_resv #(.XLEN(XLEN), .GRAN_LSB(GRAN_LSB)) u_resv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (resv_set),
    .clr_i    (resv_clr),
    .set_tag_i(addr_q[XLEN-1:GRAN_LSB]),
    .cmp_tag_i(req_addr_i[XLEN-1:GRAN_LSB]),
    .match_o  (resv_hit)
  );

  lrsc_data_fmt #(.XLEN(XLEN)) u_fmt (
    .size_i   (size_q),
    .ld_raw_i (mem_rdata_i),
    .st_raw_i (wdata_q),
    .ld_ext_o (ld_ext),
    .st_trim_o(st_trim)
  );

  // Order of decisions: legality, alignment, reservation, memory.
  always_comb begin
    state_d  = state_q;
    data_d   = data_q;
    retire_d = retire_q;
    exc_d    = exc_q;
    resv_set = 1'b0;
    resv_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        data_d   = '0;
        retire_d = 1'b0;
        state_d  = ST_RSP;
        if (!legal) begin
          exc_d    = EXC_ILLEGAL;
          resv_clr = 1'b1;
        end else if (!aligned) begin
          exc_d    = (req_op_i == OP_SC) ? EXC_ST_MISAL : EXC_LD_MISAL;
          resv_clr = 1'b1;
        end else if ((req_op_i == OP_SC) && !resv_hit) begin
          data_d   = XLEN'(1);
          retire_d = 1'b1;
          exc_d    = EXC_NONE;
          resv_clr = 1'b1;
        end else begin
          state_d = ST_MEM;
        end
      end
      ST_MEM: if (mem_rsp_i) begin
        state_d  = ST_RSP;
        data_d   = '0;
        retire_d = 1'b0;
        if (mem_err_i) begin
          exc_d    = (op_q == OP_SC) ? EXC_ST_FAULT : EXC_LD_FAULT;
          resv_clr = 1'b1;
        end else if (op_q == OP_LR) begin
          data_d   = ld_ext;
          retire_d = 1'b1;
          exc_d    = EXC_NONE;
          resv_set = 1'b1;
        end else begin
          data_d   = XLEN'(mem_sc_fail_i);
          retire_d = 1'b1;
          exc_d    = EXC_NONE;
          resv_clr = 1'b1;
        end
      end
      ST_RSP: if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_LR;
      aq_q     <= 1'b0;
      rl_q     <= 1'b0;
      size_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_q     <= '0;
      data_q   <= '0;
      retire_q <= 1'b0;
      exc_q    <= EXC_NONE;
    end else begin
      state_q  <= state_d;
      data_q   <= data_d;
      retire_q <= retire_d;
      exc_q    <= exc_d;
      if (accept) begin
        op_q    <= req_op_i;
        aq_q    <= req_aq_i;
        rl_q    <= req_rl_i;
        size_q  <= req_size_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        rd_q    <= req_rd_i;
      end
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_MEM);
  assign mem_we_o     = (op_q == OP_SC);
  assign mem_size_o   = size_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = (op_q == OP_SC) ? st_trim : '0;
  assign mem_aq_o     = aq_q;
  assign mem_rl_o     = rl_q;
  assign rsp_valid_o  = (state_q == ST_RSP);
  assign rsp_rd_o     = rd_q;
  assign rsp_data_o   = data_q;
  assign rsp_retire_o = retire_q;
  assign rsp_exc_o    = exc_q;
endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [1:0]      req_size_i,
  input logic [2:0]      addr_lo,
  input logic            mem_req_o,
  input logic            mem_rsp_i,
  input logic            mem_we_o,
  input logic [1:0]      mem_size_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic            rsp_retire_o,
  input logic [3:0]      rsp_exc_o,
  input logic [XLEN-1:0] rsp_data_o
);
  assert_single_op_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !rsp_valid_o));

  assert_misalign_no_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_size_i == 2'd2 && addr_lo[1:0] != 2'b00)
    |=> (!mem_req_o && rsp_valid_o && !rsp_retire_o));

  assert_word_trim_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_size_o == 2'd2) |-> ((mem_wdata_o >> 32) == '0));

  assert_retire_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_retire_o == (rsp_exc_o == 4'd0)));

  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_size_o) && $stable(mem_wdata_o)));

  assert_rsp_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)
                                       && $stable(rsp_exc_o) && $stable(rsp_retire_o)));
endmodule

bind lrsc_unit lrsc_unit_chk #(.XLEN(XLEN)) u_lrsc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_size_i  (req_size_i),
  .addr_lo     (req_addr_i[2:0]),
  .mem_req_o   (mem_req_o),
  .mem_rsp_i   (mem_rsp_i),
  .mem_we_o    (mem_we_o),
  .mem_size_o  (mem_size_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_retire_o(rsp_retire_o),
  .rsp_exc_o   (rsp_exc_o),
  .rsp_data_o  (rsp_data_o)
);

// File: tb/lrsc_unit_tb_top.sv
module lrsc_unit_tb_top;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            req_valid = 1'b0, req_op = 1'b0, req_aq = 1'b0, req_rl = 1'b0;
  logic [1:0]      req_size = 2'd0;
  logic [XLEN-1:0] req_addr = '0, req_wdata = '0;
  logic [4:0]      req_rd = '0;
  logic            mem_rsp = 1'b0, mem_err = 1'b0, mem_fail = 1'b0, rsp_ready = 1'b0;
  logic [XLEN-1:0] mem_rdata = '0;
  logic            req_ready, mem_req, mem_we, mem_aq, mem_rl, rsp_valid, rsp_retire;
  logic [1:0]      mem_size;
  logic [XLEN-1:0] mem_addr, mem_wdata, rsp_data;
  logic [4:0]      rsp_rd;
  logic [3:0]      rsp_exc;

  lrsc_unit #(.XLEN(XLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_aq_i(req_aq), .req_rl_i(req_rl),
    .req_wdata_i(req_wdata), .req_rd_i(req_rd),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_aq_o(mem_aq), .mem_rl_o(mem_rl),
    .mem_rsp_i(mem_rsp), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err), .mem_sc_fail_i(mem_fail),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rd_o(rsp_rd), .rsp_data_o(rsp_data),
    .rsp_retire_o(rsp_retire), .rsp_exc_o(rsp_exc)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference reservation
  bit              m_vld = 1'b0;
  logic [XLEN-1:0] m_tag = '0;

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic do_op(input logic op, input logic [1:0] sz, input logic [XLEN-1:0] addr,
                       input logic [XLEN-1:0] wdata, input logic [XLEN-1:0] rdata,
                       input int lat, input bit err, input bit fail,
                       input bit aq, input bit rl, input int bp, input string tag);
    bit              legal, aligned, hit, go_mem, exp_ret;
    logic [3:0]      exp_exc;
    logic [XLEN-1:0] exp_data, exp_wd;
    longint unsigned nbytes;
    nbytes  = 64'd1 << sz;
    legal   = (sz == 2'd2) || (sz == 2'd3 && XLEN == 64);
    aligned = (addr % nbytes) == 0;
    hit     = m_vld && ((addr >> 3) == m_tag);
    go_mem  = legal && aligned && (op == 1'b0 || hit);
    exp_wd  = (sz == 2'd2) ? (wdata & 64'h0000_0000_FFFF_FFFF) : wdata;
    exp_ret = 1'b1;
    exp_exc = 4'd0;
    exp_data = '0;
    if (!legal) begin
      exp_ret = 1'b0; exp_exc = 4'd2; m_vld = 1'b0;
    end else if (!aligned) begin
      exp_ret = 1'b0; exp_exc = op ? 4'd6 : 4'd4; m_vld = 1'b0;
    end else if (op && !hit) begin
      exp_data = 1; m_vld = 1'b0;
    end else if (err) begin
      exp_ret = 1'b0; exp_exc = op ? 4'd7 : 4'd5; m_vld = 1'b0;
    end else if (!op) begin
      exp_data = (sz == 2'd2) ? ((rdata[31] ? 64'hFFFF_FFFF_0000_0000 : 64'h0) | (rdata & 64'hFFFF_FFFF))
                              : rdata;
      m_vld = 1'b1; m_tag = addr >> 3;
    end else begin
      exp_data = fail ? 1 : 0; m_vld = 1'b0;
    end

    @(negedge clk);
    check({tag, " R1 ready before"}, req_ready, 1'b1);
    req_valid = 1'b1; req_op = op; req_size = sz; req_addr = addr; req_wdata = wdata;
    req_aq = aq; req_rl = rl; req_rd = 5'd9;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0; req_wdata = '0;
    check({tag, " R1 busy"}, req_ready, 1'b0);
    check({tag, " R3/R6 mem issue"}, mem_req, go_mem);
    if (go_mem) begin
      check({tag, " R4/R7 mem dir"}, mem_we, op);
      check({tag, " R4 mem addr"}, mem_addr, addr);
      check({tag, " R4 mem size"}, mem_size, sz);
      if (op) check({tag, " R7 wdata"}, mem_wdata, exp_wd);
      check({tag, " R10 aq"}, mem_aq, aq);
      check({tag, " R10 rl"}, mem_rl, rl);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check({tag, " R10 hold req"}, mem_req, 1'b1);
        check({tag, " R10 hold addr"}, mem_addr, addr);
        check({tag, " R1 no rsp"}, rsp_valid, 1'b0);
      end
      mem_rsp = 1'b1; mem_rdata = rdata; mem_err = err; mem_fail = fail;
      @(negedge clk);
      mem_rsp = 1'b0; mem_rdata = '0; mem_err = 1'b0; mem_fail = 1'b0;
      check({tag, " R10 req drop"}, mem_req, 1'b0);
    end
    for (int i = 0; i <= bp; i++) begin
      if (i > 0) @(negedge clk);
      check({tag, " R11 rsp valid"}, rsp_valid, 1'b1);
      check({tag, " R1 ready low"}, req_ready, 1'b0);
      check({tag, " R4/R6/R7 data"}, rsp_data, exp_data);
      check({tag, " R2/R3/R9 retire"}, rsp_retire, exp_ret);
      check({tag, " R2/R3/R9 cause"}, rsp_exc, exp_exc);
      check({tag, " R4 rd"}, rsp_rd, 5'd9);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, " R1 idle"}, req_ready, 1'b1);
    check({tag, " R11 rsp drop"}, rsp_valid, 1'b0);
  endtask

  localparam logic [XLEN-1:0] WD = 64'hAAAA_BBBB_1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready, 1'b1);
    check("R1 reset rsp", rsp_valid, 1'b0);
    check("R1 reset mem", mem_req, 1'b0);
    rst_n = 1'b1;
    // R4/R5 word LR sign extension, R7 matching word SC in same doubleword
    do_op(0, 2, 64'h100, 0, 64'h0000_0000_8000_0001, 0, 0, 0, 1, 0, 0, "lr.w");
    do_op(1, 2, 64'h104, WD, 0, 1, 0, 0, 0, 1, 0, "R7 sc.w hit");
    do_op(1, 2, 64'h104, WD, 0, 0, 0, 0, 0, 0, 0, "R8 sc.w after sc");
    // R6 tag mismatch, R8 clear after failed SC
    do_op(0, 3, 64'h200, 0, 64'h1122_3344_5566_7788, 2, 0, 0, 1, 1, 0, "R4 lr.d");
    do_op(1, 3, 64'h208, WD, 0, 0, 0, 0, 0, 0, 0, "R6 sc.d miss");
    do_op(1, 3, 64'h200, WD, 0, 0, 0, 0, 0, 0, 0, "R8 sc.d after miss");
    // R7 memory reports write not performed
    do_op(0, 3, 64'h300, 0, 64'h5, 0, 0, 0, 0, 0, 0, "lr.d");
    do_op(1, 3, 64'h300, WD, 0, 3, 0, 1, 1, 1, 2, "R7 sc.d fail");
    do_op(1, 3, 64'h300, WD, 0, 0, 0, 0, 0, 0, 0, "R8 sc.d after fail");
    // R3 misaligned loads
    do_op(0, 2, 64'h102, 0, 0, 0, 0, 0, 0, 0, 0, "R3 lr.w mis");
    do_op(0, 3, 64'h304, 0, 0, 0, 0, 0, 0, 0, 0, "R3 lr.d mis");
    // R3 misaligned SC with matching tag traps and clears
    do_op(0, 2, 64'h400, 0, 64'h7FFF_FFFF, 0, 0, 0, 0, 0, 0, "lr.w pos");
    do_op(1, 2, 64'h402, WD, 0, 0, 0, 0, 0, 0, 0, "R3 sc.w mis");
    do_op(1, 2, 64'h400, WD, 0, 0, 0, 0, 0, 0, 0, "R8 sc after trap");
    // R2 illegal widths
    do_op(0, 0, 64'h500, 0, 0, 0, 0, 0, 0, 0, 0, "R2 lr.b");
    do_op(1, 1, 64'h500, WD, 0, 0, 0, 0, 0, 0, 0, "R2 sc.h");
    // R9 memory errors
    do_op(0, 2, 64'h600, 0, 64'h1, 0, 0, 0, 0, 0, 0, "lr.w");
    do_op(0, 2, 64'h608, 0, 64'h1, 1, 1, 0, 0, 0, 0, "R9 lr err");
    do_op(1, 2, 64'h600, WD, 0, 0, 0, 0, 0, 0, 0, "R8 sc after err");
    do_op(0, 2, 64'h700, 0, 64'h1, 0, 0, 0, 0, 0, 0, "lr.w");
    do_op(1, 2, 64'h700, WD, 0, 0, 1, 0, 0, 0, 1, "R9 sc err");
    // R8 reset clears reservation
    do_op(0, 3, 64'h800, 0, 64'h2, 0, 0, 0, 0, 0, 0, "lr.d");
    @(negedge clk);
    rst_n = 1'b0;
    m_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_op(1, 3, 64'h800, WD, 0, 0, 0, 0, 0, 0, 0, "R8 sc after reset");
    finish_run();
  end
endmodule